// File: doc/BRIEF.md
# System Management Base Relocation Register

This block keeps the base address that system management mode uses for its handler entry point and its context save area. From that base it derives two addresses: the handler entry vector, a fixed 32 KiB above the base, and the top byte of the save area, 64 KiB minus one above the base. After reset the base holds a fixed default.

While the handler runs, software can put a new base into a slot register. The block latches the slot into a pending register only when a resume-from-SMM strobe arrives. At that point the value must be aligned to 32 KiB. The pending value becomes the live base at the next recognised SMI. If the latched slot value is not aligned, the pending value is left unchanged. The block then raises a shutdown request, which stays raised until reset. Outside management mode, slot writes and resume strobes have no effect.

Top module: `smm_reloc_base`

## Requirements
- R1: After reset the base is 0x0003_0000, the entry vector is 0x0003_8000, the save-area top is 0x0003_FFFF and shutdown is low. The slot and pending registers also hold 0x0003_0000.
- R2: The entry vector output always equals the base output plus 0x8000, modulo 2^32.
- R3: The save-area top output always equals the base output plus 0xFFFF, modulo 2^32.
- R4: A slot write is accepted only while in management mode. This mode is entered at a recognised SMI and left at the next resume. On resume, an aligned slot value is copied into the pending register.
- R5: The base changes only on the clock edge that recognises an SMI, and it then takes the pending value. A resume by itself leaves the base unchanged.
- R6: On a resume where any of slot bits 14:0 is set, shutdown rises on that edge and the pending register and base keep their values. The base's low 15 bits are always zero.
- R7: Shutdown stays set until reset. While it is set, SMI, resume and slot writes have no effect on any output.
- R8: A slot write made outside management mode is ignored. A following SMI and resume leave the base unchanged and do not raise shutdown.
- R9: A resume strobe outside management mode is ignored. An SMI strobe is recognised only outside management mode.
- R10: When a slot write and a resume fall on the same edge, the resume latches the slot value from before that write. The written value stays in the slot for the next handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| slot_wr_en_i | input | 1 | Write strobe for the save-area base slot |
| slot_wr_data_i | input | 32 | Value written into the slot |
| resume_i | input | 1 | Resume-from-SMM strobe |
| smi_i | input | 1 | SMI recognition strobe |
| reloc_base_o | output | 32 | Live relocation base |
| handler_entry_o | output | 32 | Handler entry vector (base + 0x8000) |
| save_top_o | output | 32 | Top of context save area (base + 0xFFFF) |
| shutdown_o | output | 1 | Sticky shutdown request |

## Verification
The relocation path is driven with aligned bases that are far apart. This separates a value that takes effect at the resume from one that waits for the next SMI. Two kinds of misaligned slot value are used, one with bit 14 set and one with only bit 0 set, so a checker that tests too few low bits is caught. A slot write placed on the same edge as a resume, followed by a stray resume outside the mode, shows whether the capture takes the old slot value and whether resumes outside the mode are ignored. Random mixes of strobes, writes and occasional misaligned values then exercise the mode tracking against a reference model in the bench.

// File: rtl/reloc_pkg.sv
`timescale 1ns/1ps
package reloc_pkg;

    // Operating mode of the relocation logic
    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_SMM  = 2'd1,
        MODE_HALT = 2'd2
    } reloc_mode_e;

    // Qualified events handed from the mode tracker to the datapath
    typedef struct packed {
        logic enter;    // SMI recognised
        logic leave;    // resume accepted
        logic slot_wr;  // slot write accepted
    } reloc_ctl_t;

    // True when the low n bits of v are all zero
    function automatic logic low_bits_clear(input logic [63:0] v, input int unsigned n);
        logic acc;
        acc = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if ((i < n) && v[i]) acc = 1'b0;
        end
        return acc;
    endfunction

endpackage

// File: rtl/reloc_mode_fsm.sv
`timescale 1ns/1ps
module reloc_mode_fsm
    import reloc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       smi_i,
    input  logic       resume_i,
    input  logic       slot_wr_en_i,
    input  logic       slot_ok_i,
    output reloc_ctl_t ctl_o,
    output logic       halted_o
);

    reloc_mode_e state_q;

    always_comb begin
        ctl_o.enter   = smi_i        && (state_q == MODE_RUN);
        ctl_o.leave   = resume_i     && (state_q == MODE_SMM);
        ctl_o.slot_wr = slot_wr_en_i && (state_q == MODE_SMM);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= MODE_RUN;
        end else begin
            case (state_q)
                MODE_RUN:  if (ctl_o.enter) state_q <= MODE_SMM;
                MODE_SMM:  if (ctl_o.leave) state_q <= slot_ok_i ? MODE_RUN : MODE_HALT;
                MODE_HALT: state_q <= MODE_HALT;
                default:   state_q <= MODE_HALT;
            endcase
        end
    end

    assign halted_o = (state_q == MODE_HALT);

    // R7: shutdown is sticky until reset
    a_r7_halt_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        halted_o |=> halted_o);

    // R6: shutdown only ever follows a resume with a misaligned slot
    a_r6_halt_cause: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(halted_o) |-> $past(ctl_o.leave && !slot_ok_i));

    // R9: an SMI strobe inside the mode does not restart entry
    a_r9_no_nested_enter: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != MODE_RUN) |-> !ctl_o.enter);

endmodule

// File: rtl/reloc_slot.sv
`timescale 1ns/1ps
module reloc_slot
    import reloc_pkg::*;
#(
    parameter int unsigned     AW         = 32,
    parameter int unsigned     ALIGN_BITS = 15,
    parameter logic [AW-1:0]   RESET_BASE = 32'h0003_0000
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          wr_take_i,
    input  logic          leave_i,
    input  logic [AW-1:0] wr_data_i,
    output logic          slot_ok_o,
    output logic [AW-1:0] pending_o
);

    logic [AW-1:0] slot_q;
    logic [AW-1:0] pending_q;

    assign slot_ok_o = low_bits_clear(64'(slot_q), ALIGN_BITS);
    assign pending_o = pending_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            slot_q    <= RESET_BASE;
            pending_q <= RESET_BASE;
        end else begin
            if (wr_take_i)              slot_q    <= wr_data_i;
            if (leave_i && slot_ok_o)   pending_q <= slot_q;
        end
    end

    // R6: the pending base never holds a misaligned value
    a_r6_pending_aligned: assert property (@(posedge clk_i) disable iff (rst_i)
        pending_q[ALIGN_BITS-1:0] == '0);

    // R4: the pending base moves only on an accepted resume
    a_r4_pending_on_leave: assert property (@(posedge clk_i) disable iff (rst_i)
        (pending_q != $past(pending_q)) |-> $past(leave_i));

endmodule

// File: rtl/reloc_base.sv
`timescale 1ns/1ps
module reloc_base #(
    parameter int unsigned     AW         = 32,
    parameter int unsigned     ALIGN_BITS = 15,
    parameter logic [AW-1:0]   RESET_BASE = 32'h0003_0000
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          enter_i,
    input  logic [AW-1:0] pending_i,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] entry_o,
    output logic [AW-1:0] top_o
);

    localparam logic [AW-1:0] ONE       = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] ENTRY_OFS = ONE << ALIGN_BITS;
    localparam logic [AW-1:0] TOP_OFS   = (ENTRY_OFS << 1) - ONE;

    logic [AW-1:0] base_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)        base_q <= RESET_BASE;
        else if (enter_i) base_q <= pending_i;
    end

    assign base_o  = base_q;
    assign entry_o = base_q + ENTRY_OFS;
    assign top_o   = base_q + TOP_OFS;

    // R5: the live base changes only at a recognised SMI
    a_r5_base_on_enter: assert property (@(posedge clk_i) disable iff (rst_i)
        (base_q != $past(base_q)) |-> $past(enter_i));

    // R6: the live base stays 32 KiB aligned
    a_r6_base_aligned: assert property (@(posedge clk_i) disable iff (rst_i)
        base_q[ALIGN_BITS-1:0] == '0);

endmodule

// File: rtl/smm_reloc_base.sv
`timescale 1ns/1ps
module smm_reloc_base
    import reloc_pkg::*;
#(
    parameter int unsigned     AW         = 32,
    parameter int unsigned     ALIGN_BITS = 15,
    parameter logic [AW-1:0]   RESET_BASE = 32'h0003_0000
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          slot_wr_en_i,
    input  logic [AW-1:0] slot_wr_data_i,
    input  logic          resume_i,
    input  logic          smi_i,
    output logic [AW-1:0] reloc_base_o,
    output logic [AW-1:0] handler_entry_o,
    output logic [AW-1:0] save_top_o,
    output logic          shutdown_o
);

    reloc_ctl_t    ctl;
    logic          slot_ok;
    logic [AW-1:0] pending;

    reloc_mode_fsm u_mode (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .smi_i        (smi_i),
        .resume_i     (resume_i),
        .slot_wr_en_i (slot_wr_en_i),
        .slot_ok_i    (slot_ok),
        .ctl_o        (ctl),
        .halted_o     (shutdown_o)
    );

    reloc_slot #(.AW(AW), .ALIGN_BITS(ALIGN_BITS), .RESET_BASE(RESET_BASE)) u_slot (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_take_i (ctl.slot_wr),
        .leave_i   (ctl.leave),
        .wr_data_i (slot_wr_data_i),
        .slot_ok_o (slot_ok),
        .pending_o (pending)
    );

    reloc_base #(.AW(AW), .ALIGN_BITS(ALIGN_BITS), .RESET_BASE(RESET_BASE)) u_base (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .enter_i   (ctl.enter),
        .pending_i (pending),
        .base_o    (reloc_base_o),
        .entry_o   (handler_entry_o),
        .top_o     (save_top_o)
    );

    // R7: once shutdown is raised the base is frozen
    a_r7_base_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        shutdown_o |=> $stable(reloc_base_o));

endmodule

// File: tb/smm_reloc_base_bench.sv
`timescale 1ns/1ps
module smm_reloc_base_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        we, res, smi;
    logic [31:0] wd;
    logic [31:0] base_o, entry_o, top_o;
    logic        sd_o;

    logic [31:0] m_base, m_pend, m_slot;
    bit          m_in, m_sd;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    smm_reloc_base u_smm_reloc_base (
        .clk_i           (clk),
        .rst_i           (rst),
        .slot_wr_en_i    (we),
        .slot_wr_data_i  (wd),
        .resume_i        (res),
        .smi_i           (smi),
        .reloc_base_o    (base_o),
        .handler_entry_o (entry_o),
        .save_top_o      (top_o),
        .shutdown_o      (sd_o)
    );

    function automatic logic [31:0] exp_entry(input logic [31:0] b);
        return b + 32'h0000_8000;
    endfunction

    function automatic logic [31:0] exp_top(input logic [31:0] b);
        return b + 32'h0000_FFFF;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check("R5 base", base_o, m_base);
        check("R2 entry", entry_o, exp_entry(m_base));
        check("R3 top", top_o, exp_top(m_base));
        check("R6 shutdown", {31'd0, sd_o}, {31'd0, m_sd});
    endtask

    task automatic step(input bit s, input bit r, input bit w, input logic [31:0] d);
        logic [31:0] nb, np, ns;
        bit ni, nsd;
        @(negedge clk);
        smi = s; res = r; we = w; wd = d;
        @(posedge clk);
        nb = m_base; np = m_pend; ns = m_slot; ni = m_in; nsd = m_sd;
        if (s && !m_in && !m_sd) begin nb = m_pend; ni = 1; end
        if (r && m_in) begin
            ni = 0;
            if (m_slot[14:0] == 15'd0) np = m_slot;
            else nsd = 1;
        end
        if (w && m_in) ns = d;
        m_base = nb; m_pend = np; m_slot = ns; m_in = ni; m_sd = nsd;
        #1;
        check_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; smi = 0; res = 0; we = 0; wd = '0;
        repeat (4) @(posedge clk);
        m_base = 32'h0003_0000; m_pend = 32'h0003_0000; m_slot = 32'h0003_0000;
        m_in = 0; m_sd = 0;
        @(negedge clk);
        rst = 0;
        check("R1 base", base_o, 32'h0003_0000);
        check("R1 entry", entry_o, 32'h0003_8000);
        check("R1 top", top_o, 32'h0003_FFFF);
        check("R1 shutdown", {31'd0, sd_o}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        do_reset();

        // R8: write outside the mode, then an SMI/resume round trip
        step(0, 0, 1, 32'h0000_1234);
        step(1, 0, 0, '0);
        step(0, 1, 0, '0);
        check("R8 no shutdown", {31'd0, sd_o}, 32'd0);
        step(1, 0, 0, '0);
        check("R8 base kept", base_o, 32'h0003_0000);
        step(0, 1, 0, '0);

        // R4/R5: relocation takes effect only at the next SMI
        step(1, 0, 0, '0);
        step(0, 0, 1, 32'h00A0_8000);
        check("R5 base before resume", base_o, 32'h0003_0000);
        step(0, 1, 0, '0);
        check("R5 base after resume", base_o, 32'h0003_0000);
        step(1, 0, 0, '0);
        check("R4 base relocated", base_o, 32'h00A0_8000);
        check("R2 entry relocated", entry_o, 32'h00A1_0000);
        check("R3 top relocated", top_o, 32'h00A1_7FFF);

        // R10 + R9: write on the resume edge, then a stray resume
        step(0, 0, 1, 32'h0070_0000);
        step(0, 1, 1, 32'h0090_0000);
        step(0, 1, 0, '0);
        step(1, 0, 0, '0);
        check("R10 old slot captured", base_o, 32'h0070_0000);
        check("R9 stray resume ignored", base_o, 32'h0070_0000);
        step(0, 1, 0, '0);
        step(1, 0, 0, '0);
        check("R10 new slot kept", base_o, 32'h0090_0000);

        // R6/R7: misaligned value with bit 14 set
        step(0, 0, 1, 32'h000C_4000);
        step(0, 1, 0, '0);
        check("R6 shutdown raised", {31'd0, sd_o}, 32'd1);
        check("R6 base kept", base_o, 32'h0090_0000);
        step(1, 0, 0, '0);
        step(0, 0, 1, 32'h0010_0000);
        step(0, 1, 0, '0);
        step(1, 0, 0, '0);
        check("R7 shutdown sticky", {31'd0, sd_o}, 32'd1);
        check("R7 base frozen", base_o, 32'h0090_0000);
        do_reset();

        // R6: only bit 0 set
        step(1, 0, 0, '0);
        step(0, 0, 1, 32'h0010_0001);
        step(0, 1, 0, '0);
        check("R6 bit0 shutdown", {31'd0, sd_o}, 32'd1);
        do_reset();

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            if (m_sd && ($urandom_range(0, 3) == 0)) begin
                do_reset();
            end else begin
                v = $urandom() & 32'hFFFF_8000;
                if ($urandom_range(0, 39) == 0) v = v | (32'd1 << $urandom_range(0, 14));
                step($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                     $urandom_range(0, 2) == 0, v);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule